// File: doc/BRIEF.md
# Read-Side Width Converter with Byte Ordering

This block sits at the read end of a FIFO whose storage holds 18-bit words. It presents those words on a read port that is either 18 bits or 9 bits wide. In wide mode each accepted read takes one whole word. In narrow mode each stored word leaves as two 9-bit bytes on two consecutive accepted reads. The word is popped from storage only after its second byte has been taken.

Three straps are captured while master reset is held: the write-side width, the read-side width and the byte order. After reset they are frozen. The byte-order strap decides which half of each word is delivered first in narrow mode.

The block also drives a unit indicator for the occupancy logic. It counts in bytes only when both ports are narrow. In every other case the wider bus sets the unit, so it counts in words. The storage side always delivers packed 18-bit words. Any packing of narrow writes is done on the write side.

Top module: `bmc_width_conv`

## Requirements
- R1: The three straps are captured only on clock edges where `mrst_i` is high. Strap changes while `mrst_i` is low have no effect on data order, pop behaviour or `unit_byte_o`.
- R2: With the read-width strap low (18-bit read), `rd_data_o` equals `wd_data_i` unchanged. `wd_pop_o` is high on every accepted read, meaning `rd_en_i` and `rd_valid_o` are both high.
- R3: With the read-width strap high and the order strap low, the first byte of a word is `wd_data_i[17:9]` and the second is `wd_data_i[8:0]`. Each byte appears on `rd_data_o[8:0]`, and `rd_data_o[17:9]` is zero.
- R4: With the read-width strap high and the order strap high, the first byte is `wd_data_i[8:0]` and the second is `wd_data_i[17:9]`. The same output placement applies.
- R5: In narrow mode, `wd_pop_o` is high only on the accepted read of a word's second byte. It is never high on two consecutive cycles.
- R6: Master reset returns the byte phase to the first byte. The first accepted read after reset returns the first byte of the presented word, even when reset came between the two bytes of a word.
- R7: `rd_valid_o` is low while `wd_valid_i` is low or `mrst_i` is high. A read request without a valid word neither pops nor advances the byte phase.
- R8: `unit_byte_o` is high exactly when both the write-width and read-width straps were high at reset. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_i | input | 1 | Master reset, synchronous, active high; straps are sampled while high |
| strap_in_narrow_i | input | 1 | Write-side width strap, 1 = 9-bit |
| strap_out_narrow_i | input | 1 | Read-side width strap, 1 = 9-bit |
| strap_little_i | input | 1 | Byte-order strap, 1 = low byte first |
| wd_valid_i | input | 1 | Storage has a word to present |
| wd_data_i | input | 18 | Word at the head of storage |
| wd_pop_o | output | 1 | Remove the head word from storage |
| rd_en_i | input | 1 | Read request |
| rd_valid_o | output | 1 | Read data is valid |
| rd_data_o | output | 18 | Read data; in narrow mode the byte sits in bits 8:0 |
| unit_byte_o | output | 1 | Occupancy counts bytes (1) or words (0) |

## Verification
The hardest state to reach from the ports is a master reset that lands between the two bytes of a word. The block then has to drop its half-consumed phase while the same word is still at the head of storage. The stimulus steers there directly: it takes exactly one narrow byte, re-asserts reset with the word still presented, and checks that the next read returns that word's first byte. Random valid and read-request patterns, under all four combinations of width and order, also cover reads that stall mid-word. Straps are scrambled after every reset to show that the latched configuration governs.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    parameter int BYTE_W = 9;
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic in_narrow;
        logic out_narrow;
        logic little;
    } bmc_cfg_t;
endpackage

// File: rtl/bmc_cfg_latch.sv
module bmc_cfg_latch
    import bmc_pkg::*;
(
    input  logic     clk,
    input  logic     mrst_i,
    input  logic     in_narrow_i,
    input  logic     out_narrow_i,
    input  logic     little_i,
    output bmc_cfg_t cfg_o,
    output logic     unit_byte_o
);
    bmc_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mrst_i) begin
            cfg_d.in_narrow  = in_narrow_i;
            cfg_d.out_narrow = out_narrow_i;
            cfg_d.little     = little_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o       = cfg_q;
    assign unit_byte_o = cfg_q.in_narrow & cfg_q.out_narrow;

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (mrst_i)
        (!mrst_i && $past(!mrst_i)) |-> $stable(cfg_q));
endmodule

// File: rtl/bmc_byte_seq.sv
module bmc_byte_seq (
    input  logic clk,
    input  logic mrst_i,
    input  logic narrow_i,
    input  logic wd_valid_i,
    input  logic rd_en_i,
    output logic rd_valid_o,
    output logic wd_pop_o,
    output logic phase_o
);
    typedef struct packed {
        logic phase;
    } seq_t;

    seq_t st_d, st_q;
    logic accept;

    always_comb begin
        rd_valid_o = wd_valid_i & ~mrst_i;
        accept     = rd_en_i & rd_valid_o;
        wd_pop_o   = accept & (~narrow_i | st_q.phase);
        st_d       = st_q;
        if (mrst_i) begin
            st_d.phase = 1'b0;
        end else if (accept && narrow_i) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R5
    pop_needs_read_chk: assert property (@(posedge clk) disable iff (mrst_i)
        wd_pop_o |-> (rd_en_i && wd_valid_i));

    // R5
    no_double_pop_chk: assert property (@(posedge clk) disable iff (mrst_i)
        (narrow_i && wd_pop_o) |=> !wd_pop_o);

    // R6
    phase_cleared_chk: assert property (@(posedge clk) disable iff (mrst_i)
        $fell(mrst_i) |-> (st_q.phase == 1'b0));

    // R7
    idle_holds_phase_chk: assert property (@(posedge clk) disable iff (mrst_i)
        !wd_valid_i |=> $stable(st_q.phase));

    // R7
    no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (mrst_i)
        !wd_valid_i |-> !wd_pop_o);
endmodule

// File: rtl/bmc_lane_sel.sv
module bmc_lane_sel
    import bmc_pkg::*;
(
    input  logic              narrow_i,
    input  logic              little_i,
    input  logic              phase_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] data_o
);
    logic [BYTE_W-1:0] hi_byte, lo_byte, first_b, second_b;

    always_comb begin
        hi_byte  = word_i[WORD_W-1:BYTE_W];
        lo_byte  = word_i[BYTE_W-1:0];
        first_b  = little_i ? lo_byte : hi_byte;
        second_b = little_i ? hi_byte : lo_byte;
        if (narrow_i) begin
            data_o = {{BYTE_W{1'b0}}, (phase_i ? second_b : first_b)};
        end else begin
            data_o = word_i;
        end
    end
endmodule

// File: rtl/bmc_width_conv.sv
module bmc_width_conv
    import bmc_pkg::*;
(
    input  logic              clk,
    input  logic              mrst_i,
    input  logic              strap_in_narrow_i,
    input  logic              strap_out_narrow_i,
    input  logic              strap_little_i,
    input  logic              wd_valid_i,
    input  logic [WORD_W-1:0] wd_data_i,
    output logic              wd_pop_o,
    input  logic              rd_en_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              unit_byte_o
);
    bmc_cfg_t cfg;
    logic     phase;

    bmc_cfg_latch u_cfg (
        .clk          (clk),
        .mrst_i       (mrst_i),
        .in_narrow_i  (strap_in_narrow_i),
        .out_narrow_i (strap_out_narrow_i),
        .little_i     (strap_little_i),
        .cfg_o        (cfg),
        .unit_byte_o  (unit_byte_o)
    );

    bmc_byte_seq u_seq (
        .clk        (clk),
        .mrst_i     (mrst_i),
        .narrow_i   (cfg.out_narrow),
        .wd_valid_i (wd_valid_i),
        .rd_en_i    (rd_en_i),
        .rd_valid_o (rd_valid_o),
        .wd_pop_o   (wd_pop_o),
        .phase_o    (phase)
    );

    bmc_lane_sel u_sel (
        .narrow_i (cfg.out_narrow),
        .little_i (cfg.little),
        .phase_i  (phase),
        .word_i   (wd_data_i),
        .data_o   (rd_data_o)
    );
endmodule

// File: tb/bmc_width_conv_bench.sv
module bmc_width_conv_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        mrst = 1'b1;
    logic        s_in = 1'b0, s_out = 1'b0, s_lit = 1'b0;
    logic        wd_valid = 1'b0;
    logic [17:0] wd_data = '0;
    logic        rd_en = 1'b0;
    logic        wd_pop, rd_valid, unit_byte;
    logic [17:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic        m_in, m_out, m_lit, m_phase;
    logic [17:0] cur_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmc_width_conv u_bmc_width_conv (
        .clk(clk), .mrst_i(mrst),
        .strap_in_narrow_i(s_in), .strap_out_narrow_i(s_out), .strap_little_i(s_lit),
        .wd_valid_i(wd_valid), .wd_data_i(wd_data), .wd_pop_o(wd_pop),
        .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .unit_byte_o(unit_byte)
    );

    function automatic logic [17:0] exp_data(logic [17:0] w, logic nar, logic lit, logic ph);
        logic [8:0] f, s;
        f = lit ? w[8:0] : w[17:9];
        s = lit ? w[17:9] : w[8:0];
        if (!nar) return w;
        return {9'd0, ph ? s : f};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic new_word();
        logic [31:0] r;
        r = $urandom;
        cur_word = r[17:0];
    endtask

    task automatic do_reset(input logic i_n, input logic o_n, input logic lit);
        @(negedge clk);
        mrst = 1'b1; s_in = i_n; s_out = o_n; s_lit = lit;
        wd_valid = 1'b1; rd_en = 1'b1; wd_data = cur_word;
        for (int k = 0; k < 3; k++) begin
            #1;
            // R7: nothing valid or popped during reset
            chk(rd_valid == 1'b0, "R7 valid in reset", {17'd0, rd_valid}, 18'd0);
            chk(wd_pop == 1'b0, "R7 pop in reset", {17'd0, wd_pop}, 18'd0);
            @(negedge clk);
        end
        mrst = 1'b0; rd_en = 1'b0; wd_valid = 1'b0;
        m_in = i_n; m_out = o_n; m_lit = lit; m_phase = 1'b0;
        // R1: scramble straps after reset
        s_in = ~i_n; s_out = ~o_n; s_lit = ~lit;
        #1;
        // R8
        chk(unit_byte == (m_in & m_out), "R8 unit", {17'd0, unit_byte}, {17'd0, m_in & m_out});
    endtask

    task automatic step(input logic en, input logic vld);
        logic ep;
        @(negedge clk);
        rd_en = en; wd_valid = vld; wd_data = cur_word;
        #1;
        // R7
        chk(rd_valid == vld, "R7 valid", {17'd0, rd_valid}, {17'd0, vld});
        ep = en && vld && (!m_out || m_phase);
        if (en && vld) begin
            // R2 / R3 / R4
            chk(rd_data == exp_data(cur_word, m_out, m_lit, m_phase),
                !m_out ? "R2 data" : (m_lit ? "R4 data" : "R3 data"),
                rd_data, exp_data(cur_word, m_out, m_lit, m_phase));
        end
        // R5 / R7
        chk(wd_pop == ep, "R5 pop", {17'd0, wd_pop}, {17'd0, ep});
        @(posedge clk);
        if (en && vld && m_out) m_phase = ~m_phase;
        if (ep) new_word();
    endtask

    initial begin
        logic [31:0] r;
        r = $urandom(1234);
        new_word();
        do_reset(1'b0, 1'b0, 1'b0);
        // R8 all strap combinations, R1 scrambled straps
        for (int c = 0; c < 8; c++) begin
            do_reset(c[2], c[1], c[0]);
            for (int n = 0; n < 400; n++) begin
                r = $urandom;
                step(r[0] | r[1], r[2] | r[3]);
                // R1: toggle straps while running
                s_lit = r[4]; s_out = r[5]; s_in = r[6];
            end
        end
        // R3 directed: big-endian sequence with stalls
        do_reset(1'b0, 1'b1, 1'b0);
        cur_word = 18'h2_A5C3;
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        // R6: reset between bytes of a word
        do_reset(1'b1, 1'b1, 1'b1);
        cur_word = 18'h1_3C07;
        step(1'b1, 1'b1);
        do_reset(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        rd_en = 1'b1; wd_valid = 1'b1; wd_data = cur_word;
        #1;
        chk(rd_data == {9'd0, cur_word[8:0]}, "R6 first byte after reset", rd_data, {9'd0, cur_word[8:0]});
        chk(wd_pop == 1'b0, "R6 no pop on first byte", {17'd0, wd_pop}, 18'd0);
        @(negedge clk);
        rd_en = 1'b0; wd_valid = 1'b0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < 100000; w++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule